// File: doc/BRIEF.md
# Page-Confined Stream Prefetcher

The block watches the miss stream of a cache, one missed block address per cycle at most. It looks for a short run of nearby misses inside one 4 KB page. When two misses in a row land in the same page and are fewer than 256 bytes apart, it opens a stream for that page. Each stream remembers the last block referenced in its page. It asks for the block after that one, but never for a block past the end of the page.

The block holds a fixed number of stream slots, eight by default. A later miss to a page that already has a stream moves that stream on and does not open a new one. When every slot is in use, a newly qualifying page takes the slot that was used least recently. The slots share one request port. The port takes one slot's request at a time, in round-robin order, and holds it until the consumer accepts it. Addresses on both sides are block addresses: the byte address divided by the block size, which is 64 bytes by default.

Top module: `page_stream_prefetcher`

## Requirements
- R1: At most NUM_STREAMS streams exist at once, and no two live streams cover the same page. The page is the block address with its low 6 bits dropped (4 KB page, 64-byte blocks).
- R2: A miss opens a stream when three things hold: the miss just before it, with no reset in between, lies in the same page; the block distance between the two, up or down, is 1 to 3 (under 256 bytes); and the page has no stream yet.
- R3: A miss opens no stream when its distance from the previous miss is 4 blocks or more, when it lies in another page, or when it repeats the same block.
- R4: A stream asks for the block after its most recent miss. When a miss is sampled at clock edge k and the port is free, the request shows on the port after edge k+1.
- R5: No request crosses a page. A miss at page offset 63 updates or opens its stream but produces no request.
- R6: A miss to a page that already has a stream moves that stream on to the new block and asks for the block after it. No new slot is used.
- R7: When all slots are live and a new stream qualifies, it replaces the slot whose last open or advance is oldest. A free slot is always used before any replacement.
- R8: A request on the port stays valid with the same address until pf_ready is high at a clock edge.
- R9: When several streams wait, the port serves them round-robin, starting from the slot after the last one served.
- R10: After reset there are no streams, no remembered miss and no request.
- R11: Each open or advance of a stream produces at most one request. Once that request is taken, the stream stays quiet until its next miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A cache miss is reported this cycle |
| miss_blk | input | BLK_W | Block address of the reported miss |
| pf_valid | output | 1 | A prefetch request is offered |
| pf_blk | output | BLK_W | Block address of the offered prefetch |
| pf_ready | input | 1 | The consumer accepts the offered request at this edge |

## Verification
The assertions expect miss_valid, miss_blk and pf_ready to hold known values at every edge after reset. They place no limit on how often misses arrive or how long the consumer may stall. The replacement, uniqueness and round-robin checks hold only because a page hit always wins over a new allocation and only a grant clears a waiting request. The bench therefore drives each miss for one cycle, changes pf_ready just after a rising edge, and keeps every block address within the pages it names. It stalls the port on purpose while streams build up, so that holding and round-robin order can be seen.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
   // What a sampled miss does to the stream table
   typedef enum logic [1:0] {
      MK_NONE    = 2'd0,
      MK_ADVANCE = 2'd1,
      MK_ALLOC   = 2'd2
   } miss_kind_e;

   localparam int DEF_BLK_W      = 34;
   localparam int DEF_BLK_BYTES  = 64;
   localparam int DEF_PAGE_BYTES = 4096;
   localparam int DEF_WIN_BYTES  = 256;
   localparam int DEF_STREAMS    = 8;
endpackage

// File: rtl/pfs_trigger.sv
module pfs_trigger #(
   parameter int BLK_W    = 34,
   parameter int OFF_W    = 6,
   parameter int WIN_BLKS = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             miss_valid,
   input  logic [BLK_W-1:0] miss_blk,
   output logic             qualify
);
   logic             prev_valid;
   logic [BLK_W-1:0] prev_blk;
   logic             same_page;
   logic signed [OFF_W+1:0] delta;
   logic [OFF_W+1:0]        mag;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_valid <= 1'b0;
         prev_blk   <= '0;
      end else if (miss_valid) begin
         prev_valid <= 1'b1;
         prev_blk   <= miss_blk;
      end
   end

   always_comb begin
      same_page = prev_valid && (prev_blk[BLK_W-1:OFF_W] == miss_blk[BLK_W-1:OFF_W]);
      delta     = $signed({2'b00, miss_blk[OFF_W-1:0]}) - $signed({2'b00, prev_blk[OFF_W-1:0]});
      mag       = (delta < 0) ? $unsigned(-delta) : $unsigned(delta);
      qualify   = miss_valid && same_page && (mag != '0) && (mag < (OFF_W+2)'(WIN_BLKS));
   end

   // R3: a repeated block never qualifies
   assert_no_self_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_valid && prev_valid && miss_blk == prev_blk) |-> !qualify);
endmodule

// File: rtl/pfs_lru.sv
module pfs_lru #(
   parameter int N     = 8,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             touch,
   input  logic [IDX_W-1:0] touch_idx,
   output logic [IDX_W-1:0] victim
);
   logic [IDX_W-1:0] age [N];
   logic [N-1:0]     oldest;

   always_ff @(posedge clk) begin
      for (int i = 0; i < N; i++) begin
         if (!rst_n) begin
            age[i] <= IDX_W'(i);
         end else if (touch) begin
            if (IDX_W'(i) == touch_idx)
               age[i] <= '0;
            else if (age[i] < age[touch_idx])
               age[i] <= age[i] + IDX_W'(1);
         end
      end
   end

   always_comb begin
      victim = '0;
      for (int i = 0; i < N; i++) begin
         oldest[i] = (age[i] == IDX_W'(N-1));
         if (oldest[i]) victim = IDX_W'(i);
      end
   end

   // R7: the ages stay a ranking, so exactly one slot is oldest
   assert_single_oldest_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(oldest) == 1);
endmodule

// File: rtl/pfs_rr_arb.sv
module pfs_rr_arb #(
   parameter int N     = 8,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     req,
   input  logic             advance,
   output logic             any,
   output logic [IDX_W-1:0] pick
);
   logic [IDX_W-1:0] ptr;

   always_comb begin
      any  = 1'b0;
      pick = '0;
      for (int k = 0; k < N; k++) begin
         int j;
         j = (int'(ptr) + k) % N;
         if (!any && req[j]) begin
            any  = 1'b1;
            pick = IDX_W'(j);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         ptr <= '0;
      else if (advance)
         ptr <= (pick == IDX_W'(N-1)) ? '0 : pick + IDX_W'(1);
   end

   // R9: after a grant with others waiting, another slot is served next
   assert_rotate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && $countones(req) > 1) |=> (pick != $past(pick)));
endmodule

// File: rtl/page_stream_prefetcher.sv
module page_stream_prefetcher
   import pfs_pkg::*;
#(
   parameter int BLK_W       = DEF_BLK_W,
   parameter int BLK_BYTES   = DEF_BLK_BYTES,
   parameter int PAGE_BYTES  = DEF_PAGE_BYTES,
   parameter int WIN_BYTES   = DEF_WIN_BYTES,
   parameter int NUM_STREAMS = DEF_STREAMS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             miss_valid,
   input  logic [BLK_W-1:0] miss_blk,
   output logic             pf_valid,
   output logic [BLK_W-1:0] pf_blk,
   input  logic             pf_ready
);
   localparam int BLKS_PER_PAGE = PAGE_BYTES / BLK_BYTES;
   localparam int OFF_W         = $clog2(BLKS_PER_PAGE);
   localparam int WIN_BLKS      = WIN_BYTES / BLK_BYTES;
   localparam int IDX_W         = $clog2(NUM_STREAMS);
   localparam int CNT_W         = $clog2(NUM_STREAMS + 1);

   // Elaboration-time parameter checks
   if ((BLK_BYTES & (BLK_BYTES - 1)) != 0 || BLK_BYTES < 1) begin : g_bad_blk
      $error("BLK_BYTES must be a power of two");
   end
   if ((PAGE_BYTES % BLK_BYTES) != 0 || (BLKS_PER_PAGE & (BLKS_PER_PAGE - 1)) != 0
       || BLKS_PER_PAGE < 2) begin : g_bad_page
      $error("PAGE_BYTES must be a power-of-two multiple of BLK_BYTES");
   end
   if (WIN_BLKS < 2 || WIN_BLKS > BLKS_PER_PAGE) begin : g_bad_win
      $error("WIN_BYTES must span two blocks up to one page");
   end
   if (NUM_STREAMS < 2 || (NUM_STREAMS & (NUM_STREAMS - 1)) != 0) begin : g_bad_n
      $error("NUM_STREAMS must be a power of two, at least 2");
   end
   if (BLK_W <= OFF_W) begin : g_bad_w
      $error("BLK_W must exceed the page offset width");
   end

   // Stream table
   logic [NUM_STREAMS-1:0] s_valid;
   logic [NUM_STREAMS-1:0] s_pend;
   logic [BLK_W-1:0]       s_last [NUM_STREAMS];
   logic [NUM_STREAMS-1:0] hit;

   logic             qualify;
   logic             hit_any, free_any;
   logic [IDX_W-1:0] hit_idx, free_idx, victim, touch_idx;
   miss_kind_e       kind;
   logic             touch;

   logic             pend_any, take, out_free;
   logic [IDX_W-1:0] pick;
   logic             pf_valid_q;
   logic [BLK_W-1:0] pf_blk_q;
   logic             at_page_end;

   pfs_trigger #(.BLK_W(BLK_W), .OFF_W(OFF_W), .WIN_BLKS(WIN_BLKS)) u_trigger (
      .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_blk(miss_blk),
      .qualify(qualify)
   );

   pfs_lru #(.N(NUM_STREAMS), .IDX_W(IDX_W)) u_lru (
      .clk(clk), .rst_n(rst_n), .touch(touch), .touch_idx(touch_idx), .victim(victim)
   );

   pfs_rr_arb #(.N(NUM_STREAMS), .IDX_W(IDX_W)) u_arb (
      .clk(clk), .rst_n(rst_n), .req(s_pend), .advance(take),
      .any(pend_any), .pick(pick)
   );

   // Page match per slot
   for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_match
      assign hit[g] = s_valid[g] && (s_last[g][BLK_W-1:OFF_W] == miss_blk[BLK_W-1:OFF_W]);
   end

   always_comb begin
      hit_any  = 1'b0;
      hit_idx  = '0;
      free_any = 1'b0;
      free_idx = '0;
      for (int i = NUM_STREAMS - 1; i >= 0; i--) begin
         if (hit[i]) begin
            hit_any = 1'b1;
            hit_idx = IDX_W'(i);
         end
         if (!s_valid[i]) begin
            free_any = 1'b1;
            free_idx = IDX_W'(i);
         end
      end
      // A page hit always wins over opening a new stream
      if (miss_valid && hit_any)
         kind = MK_ADVANCE;
      else if (qualify)
         kind = MK_ALLOC;
      else
         kind = MK_NONE;
      touch     = (kind != MK_NONE);
      touch_idx = (kind == MK_ADVANCE) ? hit_idx : (free_any ? free_idx : victim);
      at_page_end = (miss_blk[OFF_W-1:0] == {OFF_W{1'b1}});
      out_free  = !pf_valid_q || pf_ready;
      take      = out_free && pend_any;
   end

   for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            s_valid[g] <= 1'b0;
            s_pend[g]  <= 1'b0;
            s_last[g]  <= '0;
         end else if (touch && touch_idx == IDX_W'(g)) begin
            s_valid[g] <= 1'b1;
            s_last[g]  <= miss_blk;
            s_pend[g]  <= !at_page_end;
         end else if (take && pick == IDX_W'(g)) begin
            s_pend[g]  <= 1'b0;
         end
      end
   end

   // Registered request port
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pf_valid_q <= 1'b0;
         pf_blk_q   <= '0;
      end else if (out_free) begin
         pf_valid_q <= pend_any;
         if (take) pf_blk_q <= s_last[pick] + BLK_W'(1);
      end
   end

   assign pf_valid = pf_valid_q;
   assign pf_blk   = pf_blk_q;

   // Checking logic
   logic             dup_page;
   logic [CNT_W-1:0] live_cnt;
   always_comb begin
      dup_page = 1'b0;
      live_cnt = '0;
      for (int i = 0; i < NUM_STREAMS; i++) begin
         live_cnt = live_cnt + CNT_W'(s_valid[i]);
         for (int j = i + 1; j < NUM_STREAMS; j++)
            if (s_valid[i] && s_valid[j] &&
                s_last[i][BLK_W-1:OFF_W] == s_last[j][BLK_W-1:OFF_W])
               dup_page = 1'b1;
      end
   end

   assert_unique_page_R1: assert property (@(posedge clk) disable iff (!rst_n) !dup_page);

   assert_in_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pf_valid |-> (pf_blk[OFF_W-1:0] != '0));

   assert_no_new_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_valid && hit_any) |=> $stable(live_cnt));

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_blk)));
endmodule

// File: tb/page_stream_prefetcher_test.sv
module page_stream_prefetcher_test;
   localparam int CLK_PERIOD = 10;
   localparam int BW = 34;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          miss_valid = 1'b0;
   logic [BW-1:0] miss_blk = '0;
   logic          pf_valid;
   logic [BW-1:0] pf_blk;
   logic          pf_ready = 1'b1;

   int checks = 0;
   int fails  = 0;
   logic [BW-1:0] log_q [64];
   int log_n = 0;

   page_stream_prefetcher uut (
      .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_blk(miss_blk),
      .pf_valid(pf_valid), .pf_blk(pf_blk), .pf_ready(pf_ready)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // Record every accepted request, mid-cycle
   always @(negedge clk) begin
      if (rst_n && pf_valid && pf_ready && log_n < 64) begin
         log_q[log_n] = pf_blk;
         log_n = log_n + 1;
      end
   end

   function automatic logic [BW-1:0] blk(input int page, input int off);
      return BW'(page) * BW'(64) + BW'(off);
   endfunction

   task automatic check(input string tag, input logic [BW-1:0] got, input logic [BW-1:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic miss(input logic [BW-1:0] b);
      @(posedge clk); #1;
      miss_valid = 1'b1;
      miss_blk   = b;
      @(posedge clk); #1;
      miss_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic set_ready(input logic r);
      @(posedge clk); #1;
      pf_ready = r;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R10 no request after reset", BW'(pf_valid), BW'(0));
   endtask

   task automatic t_alloc();
      int base;
      base = log_n;
      miss(blk(1, 10));
      miss(blk(1, 12));
      @(negedge clk);
      check("R4 not yet valid one edge after miss", BW'(pf_valid), BW'(0));
      @(negedge clk);
      check("R4 valid two edges after miss", BW'(pf_valid), BW'(1));
      check("R2 R4 next block of second miss", pf_blk, blk(1, 13));
      idle(4);
      check("R11 one request per reference", BW'(log_n - base), BW'(1));
   endtask

   task automatic t_reject();
      int base;
      base = log_n;
      miss(blk(2, 0));  miss(blk(2, 4));
      miss(blk(3, 5));  miss(blk(4, 6));
      miss(blk(5, 7));  miss(blk(5, 7));
      idle(4);
      check("R3 far, cross-page or repeated miss opens nothing", BW'(log_n - base), BW'(0));
      miss(blk(6, 20)); miss(blk(6, 17));
      idle(4);
      check("R2 downward pair opens stream", BW'(log_n - base), BW'(1));
      check("R2 downward pair address", log_q[base], blk(6, 18));
   endtask

   task automatic t_advance();
      int base;
      base = log_n;
      miss(blk(1, 40));
      miss(blk(6, 60));
      idle(4);
      check("R6 advances give two requests", BW'(log_n - base), BW'(2));
      check("R6 first advance address", log_q[base], blk(1, 41));
      check("R6 second advance address", log_q[base + 1], blk(6, 61));
   endtask

   task automatic t_boundary();
      int base;
      base = log_n;
      miss(blk(1, 63));
      miss(blk(7, 61)); miss(blk(7, 63));
      idle(4);
      check("R5 nothing past page end", BW'(log_n - base), BW'(0));
      miss(blk(7, 10));
      idle(4);
      check("R5 stream at page end still live", BW'(log_n - base), BW'(1));
      check("R6 live stream address", log_q[base], blk(7, 11));
   endtask

   task automatic t_rr_hold();
      int base;
      set_ready(1'b0);
      miss(blk(8, 0));  miss(blk(8, 1));
      miss(blk(9, 0));  miss(blk(9, 2));
      miss(blk(10, 5)); miss(blk(10, 6));
      miss(blk(8, 30));
      idle(2);
      @(negedge clk);
      check("R8 held valid under stall", BW'(pf_valid), BW'(1));
      check("R8 held address under stall", pf_blk, blk(8, 2));
      idle(3);
      @(negedge clk);
      check("R8 still held later", pf_blk, blk(8, 2));
      base = log_n;
      set_ready(1'b1);
      idle(8);
      check("R9 four requests drained", BW'(log_n - base), BW'(4));
      check("R9 order 1", log_q[base],     blk(8, 2));
      check("R9 order 2", log_q[base + 1], blk(9, 3));
      check("R9 order 3", log_q[base + 2], blk(10, 7));
      check("R9 order 4 rotated", log_q[base + 3], blk(8, 31));
   endtask

   task automatic t_lru();
      int base;
      miss(blk(11, 0)); miss(blk(11, 1));
      miss(blk(12, 0)); miss(blk(12, 1));
      idle(4);
      base = log_n;
      miss(blk(13, 0)); miss(blk(13, 1));
      miss(blk(6, 5));
      miss(blk(1, 2));
      idle(4);
      check("R7 R1 replace then two requests", BW'(log_n - base), BW'(2));
      check("R7 new stream address", log_q[base], blk(13, 2));
      check("R7 least recent evicted, older-opened kept", log_q[base + 1], blk(1, 3));
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_alloc();
      t_reject();
      t_advance();
      t_boundary();
      t_rr_hold();
      t_lru();
      summary();
   end

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
   end
endmodule